// File: doc/BRIEF.md
# Load/Store-Multiple Micro-op Sequencer

This block expands a single block-transfer instruction into a stream of single-word micro-operations. It presents one micro-op per cycle on a valid/ready output. An instruction carries a 16-bit register list, a 4-bit base register index and five control bits: load/store, up/down, pre/post indexing, writeback and a privileged-mode flag.

The stream always opens with a copy of the base register into a dedicated temporary register. Every transfer then addresses memory relative to that temporary. One load or store follows for each set bit of the list, lowest register first. Each transfer carries an 8-bit immediate magnitude and a direction bit, and the immediates are laid out so that the lowest register lands at the lowest address. If writeback is requested, a final micro-op moves the base register by four bytes per transferred register. The privileged flag selects one of two variants. When the program counter (register 15) is absent from the list, every register is remapped to its user-mode copy. When register 15 is present in a load, the transfer for register 15 becomes an exception-return load. The final micro-op of each instruction is flagged, and the next instruction is accepted only after that micro-op has been taken.

Top module: `lsm_uop_seq`

## Requirements
- R1: `in_ready` is high exactly when no instruction is in flight: it is high after reset, low from the cycle after acceptance, and high again in the cycle after the micro-op flagged last has been taken (`out_valid` and `out_ready` high at a clock edge).
- R2: The first micro-op of every instruction is opcode 0 (add-immediate) with destination index 32 (the temporary), source equal to the base index, immediate 0 and direction bit 1.
- R3: Transfer micro-ops come one per set list bit, in ascending register index. Their source index is 32. Their opcode is 2 for a load and 4 for a store. Their destination is the register index (0 to 15) unless R6 or R7 applies.
- R4: The first transfer's immediate is 0 when ascending (`in_up`=1) and 4*N-4 when descending, with N the number of set bits. If `in_pre` is set, 4 is added in both cases.
- R5: Each following transfer's immediate is the previous one plus 4 when ascending, or minus 4 when descending. The direction bit of every transfer equals `in_up`.
- R6: With `in_priv` set and list bit 15 clear, every transfer's destination index is 16 plus the register index (the user-mode copy).
- R7: With `in_priv` set, a load, and list bit 15 set, the transfer for register 15 uses opcode 3 (load with status restore). All indices stay unmapped. A store with `in_priv` set and bit 15 set is plain, with no remapping.
- R8: With writeback, a final micro-op has destination and source equal to the base index and immediate 4*N. Its opcode is 0 (add) when ascending and 1 (subtract) when descending.
- R9: An instruction yields exactly 1 + N + (writeback ? 1 : 0) micro-ops. Only the final one has `out_last` set.
- R10: An empty list yields only the base copy, followed by the writeback micro-op (immediate 0) when writeback is requested. The last flag sits on the final emitted micro-op.
- R11: While `out_valid` is high and `out_ready` is low, every output field holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction accepted when in_valid is high |
| in_list | input | 16 | Register list, bit i selects register i |
| in_base | input | 4 | Base register index |
| in_load | input | 1 | 1 = load, 0 = store |
| in_up | input | 1 | 1 = ascending addresses, 0 = descending |
| in_pre | input | 1 | 1 = pre-indexed (starting offset moved by 4) |
| in_wb | input | 1 | Update base after the transfers |
| in_priv | input | 1 | Privileged variant (user-bank forcing or exception return) |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes micro-op |
| out_op | output | 3 | 0 add-imm, 1 sub-imm, 2 load, 3 load-return, 4 store |
| out_dst | output | 6 | Destination or data register index |
| out_src | output | 6 | Base register index for the micro-op |
| out_imm | output | 8 | Immediate magnitude |
| out_up | output | 1 | 1 = add immediate, 0 = subtract |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
The bench builds the block with its default parameters: a 16-bit list, 6-bit indices, an 8-bit immediate, temporary index 32 and user offset 16. With these values a full list drives the immediate up to its extreme of 64, both in a descending pre-indexed walk and in the writeback amount. Register 15 is the top list bit, so the exception-return and user-forcing variants are both reachable. Random back-pressure on `out_ready` exercises the hold rule against every micro-op kind, and the empty list reaches the two shortest sequences.

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq #(
  parameter int LIST_W   = 16,
  parameter int IDX_W    = 6,
  parameter int IMM_W    = 8,
  parameter int TEMP_IDX = 32,
  parameter int USER_OFS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LIST_W-1:0]         in_list,
  input  logic [$clog2(LIST_W)-1:0] in_base,
  input  logic                      in_load,
  input  logic                      in_up,
  input  logic                      in_pre,
  input  logic                      in_wb,
  input  logic                      in_priv,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [2:0]                out_op,
  output logic [IDX_W-1:0]          out_dst,
  output logic [IDX_W-1:0]          out_src,
  output logic [IMM_W-1:0]          out_imm,
  output logic                      out_up,
  output logic                      out_last
);
  localparam int BASE_W = $clog2(LIST_W);
  localparam int CNT_W  = $clog2(LIST_W + 1);
  localparam int PC_IDX = LIST_W - 1;
  localparam logic [IMM_W-1:0] STEP = IMM_W'(4);
  localparam logic [2:0] OP_ADDI = 3'd0, OP_SUBI = 3'd1, OP_LOAD = 3'd2,
                         OP_LRET = 3'd3, OP_STORE = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_COPY, S_XFER, S_WB} phase_t;

  phase_t              phase;
  logic [LIST_W-1:0]   rem_q;
  logic [BASE_W-1:0]   base_q;
  logic                load_q, up_q, wb_q, fuser_q, eret_q;
  logic [IMM_W-1:0]    imm_q;
  logic [CNT_W-1:0]    cnt_q;

  logic [CNT_W-1:0]    n_in;
  logic [IMM_W-1:0]    n4_in, imm0;
  logic [LIST_W-1:0]   low_bit;
  logic [BASE_W-1:0]   low_idx;
  logic                single, fire;
  logic [IDX_W-1:0]    base_ext, xfer_dst;

  assign n_in     = CNT_W'($countones(in_list));
  assign n4_in    = IMM_W'(n_in) << 2;
  assign imm0     = (in_up ? '0 : n4_in - STEP) + (in_pre ? STEP : '0);
  assign low_bit  = rem_q & (~rem_q + LIST_W'(1));
  assign single   = (rem_q == low_bit);
  assign fire     = out_valid && out_ready;
  assign base_ext = IDX_W'(base_q);
  assign xfer_dst = IDX_W'(low_idx) + (fuser_q ? IDX_W'(USER_OFS) : '0);

  always_comb begin
    low_idx = '0;
    for (int i = LIST_W - 1; i >= 0; i--)
      if (rem_q[i]) low_idx = BASE_W'(i);
  end

  assign in_ready  = (phase == S_IDLE);
  assign out_valid = (phase != S_IDLE);

  always_comb begin
    out_op   = OP_ADDI;
    out_dst  = IDX_W'(TEMP_IDX);
    out_src  = base_ext;
    out_imm  = '0;
    out_up   = 1'b1;
    out_last = 1'b0;
    case (phase)
      S_COPY: out_last = (rem_q == '0) && !wb_q;
      S_XFER: begin
        out_op   = !load_q ? OP_STORE :
                   (eret_q && low_idx == BASE_W'(PC_IDX)) ? OP_LRET : OP_LOAD;
        out_dst  = xfer_dst;
        out_src  = IDX_W'(TEMP_IDX);
        out_imm  = imm_q;
        out_up   = up_q;
        out_last = single && !wb_q;
      end
      S_WB: begin
        out_op   = up_q ? OP_ADDI : OP_SUBI;
        out_dst  = base_ext;
        out_imm  = IMM_W'(cnt_q) << 2;
        out_up   = up_q;
        out_last = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      rem_q   <= '0;
      base_q  <= '0;
      load_q  <= 1'b0;
      up_q    <= 1'b0;
      wb_q    <= 1'b0;
      fuser_q <= 1'b0;
      eret_q  <= 1'b0;
      imm_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (phase)
        S_IDLE: if (in_valid) begin
          rem_q   <= in_list;
          base_q  <= in_base;
          load_q  <= in_load;
          up_q    <= in_up;
          wb_q    <= in_wb;
          fuser_q <= in_priv && !in_list[PC_IDX];
          eret_q  <= in_priv && in_load && in_list[PC_IDX];
          imm_q   <= imm0;
          cnt_q   <= n_in;
          phase   <= S_COPY;
        end
        S_COPY: if (fire)
          phase <= (rem_q != '0) ? S_XFER : (wb_q ? S_WB : S_IDLE);
        S_XFER: if (fire) begin
          rem_q <= rem_q & ~low_bit;
          imm_q <= up_q ? imm_q + STEP : imm_q - STEP;
          if (single) phase <= wb_q ? S_WB : S_IDLE;
        end
        S_WB: if (fire) phase <= S_IDLE;
        default: phase <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> in_ready);

  a_r2_copy_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_op == OP_ADDI &&
      out_dst == IDX_W'(TEMP_IDX) && out_imm == '0 && out_up));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && phase == S_XFER) |=> (phase != S_XFER || out_dst > $past(out_dst)));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && phase == S_XFER) |=> (phase != S_XFER ||
      out_imm == ($past(out_up) ? IMM_W'($past(out_imm) + STEP)
                                : IMM_W'($past(out_imm) - STEP))));

  a_r8_wb_in_place: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && phase == S_WB) |-> (out_dst == out_src && out_last));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) &&
      $stable(out_dst) && $stable(out_src) && $stable(out_imm) &&
      $stable(out_up) && $stable(out_last)));
endmodule

// File: tb/lsm_uop_seq_test.sv
module lsm_uop_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [15:0] in_list = '0;
  logic [3:0] in_base = '0;
  logic in_load = 0, in_up = 0, in_pre = 0, in_wb = 0, in_priv = 0;
  logic out_valid, out_ready = 1'b0;
  logic [2:0] out_op;
  logic [5:0] out_dst, out_src;
  logic [7:0] out_imm;
  logic out_up, out_last;

  always #5 clk = ~clk;

  lsm_uop_seq uut (.*);

  int checks = 0, fails = 0;
  logic [24:0] exp_q[$];
  string tag_q[$];
  int ready_mode = 0;
  bit done = 0, prev_stall = 0, prev_last_fire = 0;
  logic [24:0] prev_word;

  function automatic logic [24:0] pack(logic [2:0] op, logic [5:0] d, logic [5:0] s,
                                       logic [7:0] im, logic u, logic l);
    return {op, d, s, im, u, l};
  endfunction

  task automatic check(bit ok, string tag, logic [24:0] act, logic [24:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [24:0] w;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 4) != 0;
        default: out_ready = ($urandom % 3) == 0;
      endcase
      w = {out_op, out_dst, out_src, out_imm, out_up, out_last};
      if (prev_stall) check(out_valid && w == prev_word, "R11", w, prev_word);
      if (prev_last_fire) check(in_ready === 1'b1, "R1", 25'(in_ready), 25'd1);
      if (out_valid) begin
        check(!in_ready, "R1", 25'(in_ready), 25'd0);
        if (exp_q.size() == 0) check(0, "R9", w, 25'd0);
        else begin
          check(w[24:1] == exp_q[0][24:1], tag_q[0], w, exp_q[0]);
          check(w[0] == exp_q[0][0], "R9", w, exp_q[0]);
        end
      end else if (!in_ready && exp_q.size() != 0) check(0, "R9", 25'd0, exp_q[0]);
      prev_stall = out_valid && !out_ready;
      prev_word = w;
      prev_last_fire = out_valid && out_ready && out_last;
      if (out_valid && out_ready && exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic send(logic [15:0] l, logic [3:0] b, bit ld, bit up, bit pre, bit wb, bit pv);
    int n, imm, k;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_list = l; in_base = b; in_load = ld; in_up = up;
    in_pre = pre; in_wb = wb; in_priv = pv; in_valid = 1'b1;
    n = $countones(l);
    imm = (up ? 0 : 4 * n - 4) + (pre ? 4 : 0);
    exp_q.push_back(pack(3'd0, 6'd32, 6'(b), 8'd0, 1'b1, n == 0 && !wb));
    tag_q.push_back(n == 0 ? "R10" : "R2");
    k = 0;
    for (int r = 0; r < 16; r++) begin
      if (l[r]) begin
        logic [2:0] op;
        logic [5:0] d;
        string t;
        k++;
        op = !ld ? 3'd4 : (pv && r == 15) ? 3'd3 : 3'd2;
        d = (pv && !l[15]) ? 6'(16 + r) : 6'(r);
        t = (op == 3'd3) ? "R7" : (pv && !l[15]) ? "R6" : (k == 1) ? "R4" : "R5";
        if (pv && l[15] && op != 3'd3) t = "R7";
        if (!pv && k > 1 && (k % 2) == 0) t = "R3";
        exp_q.push_back(pack(op, d, 6'd32, 8'(imm), up, k == n && !wb));
        tag_q.push_back(t);
        imm = up ? imm + 4 : imm - 4;
      end
    end
    if (wb) begin
      exp_q.push_back(pack(up ? 3'd0 : 3'd1, 6'(b), 6'(b), 8'(4 * n), up, 1'b1));
      tag_q.push_back(n == 0 ? "R10" : "R8");
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1",
          {23'd0, in_ready, out_valid}, 25'd2);
    rst_n = 1'b1;
    send(16'h0000, 4'd3, 1, 1, 0, 0, 0);
    send(16'h0000, 4'd5, 0, 0, 1, 1, 0);
    send(16'h8421, 4'd2, 1, 1, 0, 1, 0);
    send(16'hFFFF, 4'd13, 0, 0, 1, 1, 0);
    send(16'hFFFF, 4'd1, 1, 0, 0, 0, 0);
    ready_mode = 1;
    send(16'hFFFF, 4'd0, 1, 1, 1, 1, 0);
    send(16'h00F0, 4'd9, 1, 1, 0, 1, 1);
    send(16'h8003, 4'd13, 1, 0, 1, 1, 1);
    send(16'h8001, 4'd4, 0, 1, 1, 0, 1);
    send(16'h4000, 4'd7, 0, 0, 0, 1, 1);
    for (int i = 0; i < 40; i++) begin
      ready_mode = i % 3;
      send(16'($urandom), 4'($urandom % 15), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom));
    end
    ready_mode = 0;
    @(negedge clk);
    while (exp_q.size() != 0 || !in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule